// File: doc/BRIEF.md
# Microstep Phase Position Sequencer

This block tracks the electrical angle of a two-winding stepper motor. It divides one electrical cycle into 64 microsteps, so each 90-degree quadrant holds 16 steps of about 5.6 degrees. The position moves by one on every clock cycle in which the step strobe is high and the block is enabled. The direction input decides whether it counts up or down, and it may change between any two steps.

From the position, the block derives one drive word per winding. Each word has a 7-bit current magnitude, scaled as a percentage from 0 to 100, and a polarity bit that selects which bridge terminal sources the current. Winding A follows a sine and winding B a cosine. Both are read from one 17-entry quarter-wave table, which is folded by quadrant. The analog current regulation downstream uses these words as its set-points.

Top module: `microstep_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) sets `pos_o` to 0, both magnitudes to 0 and both polarity bits to 0 from that edge on.
- R2: At an edge where `en_i`=1, `step_i`=1 and `dir_i`=0, the position increases by one modulo 64, so 63 wraps to 0.
- R3: At an edge where `en_i`=1, `step_i`=1 and `dir_i`=1, the position decreases by one modulo 64, so 0 wraps to 63.
- R4: At any edge where `en_i` or `step_i` is 0, the position keeps its value.
- R5: Let q=`pos_o[5:4]` and k=`pos_o[3:0]`. Winding A uses table index k when q is even and 16-k when q is odd. Winding B uses the opposite choice. The table for indices 0 to 16 is 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100.
- R6: At k=8 in any quadrant, both windings carry magnitude 71 while enabled.
- R7: `rev_a_o` equals `pos_o[5]` and `rev_b_o` equals `pos_o[5]` XOR `pos_o[4]`. A value of 1 means the current flows in reverse. Both bits keep tracking the position while disabled.
- R8: After an edge where `en_i`=0, both magnitudes are 0.
- R9: All outputs are registered. The drive words after an edge match the position that the same edge produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable; when low, position is held and magnitudes are forced to zero |
| step_i | input | 1 | Step strobe, one microstep per high cycle |
| dir_i | input | 1 | 0 counts up, 1 counts down |
| pos_o | output | 6 | Current electrical position, 0 to 63 |
| mag_a_o | output | 7 | Winding A current magnitude, 0 to 100 |
| rev_a_o | output | 1 | Winding A current polarity |
| mag_b_o | output | 7 | Winding B current magnitude, 0 to 100 |
| rev_b_o | output | 1 | Winding B current polarity |

## Verification
The hardest states to reach are the wrap points and the odd quadrants. Position 63 can only be reached from reset by a long upward run or by one downward step that wraps below zero. The stimulus takes both paths. It steps downward from reset to reach 63 directly, and it walks a full 64-step cycle upward so that every table index is visited in both its direct and mirrored form. A vector walk also reverses direction in the middle of a run and toggles the enable while a step strobe is asserted, which shows that a strobe arriving while disabled is discarded.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
    localparam int POS_W = 6;
    localparam int OFS_W = 4;
    localparam int QTR   = 1 << OFS_W;
    localparam int MAG_W = 7;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [MAG_W-1:0] mag_t;
    typedef logic [OFS_W:0]   idx_t;

    typedef struct packed {
        mag_t mag_a;
        logic rev_a;
        mag_t mag_b;
        logic rev_b;
    } drv_t;

    typedef struct packed {
        pos_t pos;
    } ctr_t;

    // Quarter-wave sine in percent, index 0..16 spans 0..90 degrees.
    function automatic mag_t sine_lut(input idx_t idx);
        case (idx)
            5'd0:    return 7'd0;
            5'd1:    return 7'd10;
            5'd2:    return 7'd20;
            5'd3:    return 7'd29;
            5'd4:    return 7'd38;
            5'd5:    return 7'd47;
            5'd6:    return 7'd56;
            5'd7:    return 7'd63;
            5'd8:    return 7'd71;
            5'd9:    return 7'd77;
            5'd10:   return 7'd83;
            5'd11:   return 7'd88;
            5'd12:   return 7'd92;
            5'd13:   return 7'd96;
            5'd14:   return 7'd98;
            default: return 7'd100;
        endcase
    endfunction
endpackage

// File: rtl/ustep_pos_ctr.sv
module ustep_pos_ctr
    import ustep_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    input  logic dir_i,
    output pos_t pos_o,
    output pos_t pos_nxt_o
);
    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (adv_i) begin
            if (dir_i) ctr_d.pos = ctr_q.pos - pos_t'(1);
            else       ctr_d.pos = ctr_q.pos + pos_t'(1);
        end
        if (rst_i) ctr_d = '0;
    end

    always_ff @(posedge clk_i) begin
        ctr_q <= ctr_d;
    end

    assign pos_o     = ctr_q.pos;
    assign pos_nxt_o = ctr_d.pos;
endmodule

// File: rtl/ustep_wind_map.sv
module ustep_wind_map
    import ustep_pkg::*;
#(
    parameter bit COSINE = 1'b0
) (
    input  pos_t pos_i,
    input  logic en_i,
    output mag_t mag_o,
    output logic rev_o
);
    logic [1:0]       quad;
    logic [OFS_W-1:0] ofs;
    logic             mirror;
    idx_t             idx;

    always_comb begin
        quad   = pos_i[POS_W-1 -: 2];
        ofs    = pos_i[OFS_W-1:0];
        mirror = quad[0] ^ COSINE;
        idx    = mirror ? idx_t'(QTR) - {1'b0, ofs} : {1'b0, ofs};
        mag_o  = en_i ? sine_lut(idx) : '0;
        rev_o  = COSINE ? (quad[1] ^ quad[0]) : quad[1];
    end
endmodule

// File: rtl/microstep_seq.sv
module microstep_seq
    import ustep_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             step_i,
    input  logic             dir_i,
    output logic [POS_W-1:0] pos_o,
    output logic [MAG_W-1:0] mag_a_o,
    output logic             rev_a_o,
    output logic [MAG_W-1:0] mag_b_o,
    output logic             rev_b_o
);
    pos_t pos_nxt;
    mag_t wmag [2];
    logic wrev [2];
    drv_t drv_d, drv_q;

    ustep_pos_ctr ctr_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .adv_i     (en_i & step_i),
        .dir_i     (dir_i),
        .pos_o     (pos_o),
        .pos_nxt_o (pos_nxt)
    );

    for (genvar w = 0; w < 2; w++) begin : g_wind
        ustep_wind_map #(.COSINE(w == 1)) map_i (
            .pos_i (pos_nxt),
            .en_i  (en_i),
            .mag_o (wmag[w]),
            .rev_o (wrev[w])
        );
    end

    always_comb begin
        drv_d.mag_a = wmag[0];
        drv_d.rev_a = wrev[0];
        drv_d.mag_b = wmag[1];
        drv_d.rev_b = wrev[1];
        if (rst_i) drv_d = '0;
    end

    always_ff @(posedge clk_i) begin
        drv_q <= drv_d;
    end

    assign mag_a_o = drv_q.mag_a;
    assign rev_a_o = drv_q.rev_a;
    assign mag_b_o = drv_q.mag_b;
    assign rev_b_o = drv_q.rev_b;
endmodule

// File: rtl/ustep_seq_chk.sv
module ustep_seq_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic       step_i,
    input logic       dir_i,
    input logic [5:0] pos_o,
    input logic [6:0] mag_a_o,
    input logic       rev_a_o,
    input logic [6:0] mag_b_o,
    input logic       rev_b_o
);
    a_r1_reset_state: assert property (@(posedge clk_i)
        rst_i |=> (pos_o == 6'd0 && mag_a_o == 7'd0 && mag_b_o == 7'd0 && !rev_a_o && !rev_b_o));

    a_r2_cw_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && step_i && !dir_i) |=> (pos_o == 6'($past(pos_o) + 6'd1)));

    a_r3_ccw_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && step_i && dir_i) |=> (pos_o == 6'($past(pos_o) - 6'd1)));

    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_i && step_i) |=> $stable(pos_o));

    a_r5_mag_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (mag_a_o <= 7'd100 && mag_b_o <= 7'd100));

    a_r6_balance: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(en_i) && !$past(rst_i) && pos_o[3:0] == 4'd8) |-> (mag_a_o == 7'd71 && mag_b_o == 7'd71));

    a_r7_polarity: assert property (@(posedge clk_i) disable iff (rst_i)
        (rev_a_o == pos_o[5] && rev_b_o == (pos_o[5] ^ pos_o[4])));

    a_r8_zero_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (mag_a_o == 7'd0 && mag_b_o == 7'd0));
endmodule

bind microstep_seq ustep_seq_chk chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .step_i  (step_i),
    .dir_i   (dir_i),
    .pos_o   (pos_o),
    .mag_a_o (mag_a_o),
    .rev_a_o (rev_a_o),
    .mag_b_o (mag_b_o),
    .rev_b_o (rev_b_o)
);

// File: tb/microstep_seq_tb_top.sv
`timescale 1ns/1ps
module microstep_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       step = 1'b0;
    logic       dir = 1'b0;
    logic [5:0] pos;
    logic [6:0] mag_a, mag_b;
    logic       rev_a, rev_b;
    int         n_tests = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    microstep_seq dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .step_i(step), .dir_i(dir),
        .pos_o(pos), .mag_a_o(mag_a), .rev_a_o(rev_a), .mag_b_o(mag_b), .rev_b_o(rev_b)
    );

    // {en, step, dir, expected position}
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        {3'b110, 6'd1}, {3'b110, 6'd2}, {3'b110, 6'd3}, {3'b110, 6'd4},
        {3'b110, 6'd5}, {3'b110, 6'd6}, {3'b111, 6'd5}, {3'b111, 6'd4},
        {3'b111, 6'd3}, {3'b111, 6'd2}, {3'b110, 6'd3}, {3'b110, 6'd4},
        {3'b100, 6'd4}, {3'b010, 6'd4}, {3'b011, 6'd4}, {3'b111, 6'd3}
    };

    function automatic int pct(input int idx);
        int t [17] = '{0, 10, 20, 29, 38, 47, 56, 63, 71, 77, 83, 88, 92, 96, 98, 100, 100};
        return t[idx];
    endfunction

    function automatic int model_mag(input int p, input bit cosw, input bit e);
        int q = p / 16;
        int k = p % 16;
        bit odd = ((q % 2) == 1) ^ cosw;
        if (!e) return 0;
        return odd ? pct(16 - k) : pct(k);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_all(input string req, input int p, input bit e);
        int q = p / 16;
        check({req, " pos"}, pos, p);
        check({req, " magA R5"}, mag_a, model_mag(p, 1'b0, e));
        check({req, " magB R5"}, mag_b, model_mag(p, 1'b1, e));
        check({req, " revA R7"}, rev_a, (q >= 2) ? 1 : 0);
        check({req, " revB R7"}, rev_b, (q == 1 || q == 2) ? 1 : 0);
    endtask

    task automatic apply(input bit e, input bit s, input bit d);
        @(negedge clk);
        en = e; step = s; dir = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; step = 1'b1; dir = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0; step = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with en and step high during reset
        do_reset();
        check_all("R1 reset", 0, 1'b0);

        // Vector walk: R2/R3 mid-stream reversal, R4 hold, R8 disabled, R9 same-edge outputs
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][8], VEC[i][7], VEC[i][6]);
            check_all($sformatf("R9 vec%0d R2 R3 R4 R8", i), int'(VEC[i][5:0]), VEC[i][8]);
        end

        // R3: wrap below zero
        do_reset();
        apply(1'b1, 1'b1, 1'b1);
        check_all("R3 wrap 0->63", 63, 1'b1);
        check("R3 wrap magA", mag_a, 10);
        check("R3 wrap magB", mag_b, 100);
        // R2: wrap above 63
        apply(1'b1, 1'b1, 1'b0);
        check_all("R2 wrap 63->0", 0, 1'b1);

        // R2/R5/R6/R7: full upward cycle through every position
        for (int p = 1; p <= 64; p++) begin
            apply(1'b1, 1'b1, 1'b0);
            check_all("R2 cycle", p % 64, 1'b1);
            if ((p % 16) == 8) begin
                check("R6 balance A", mag_a, 71);
                check("R6 balance B", mag_b, 71);
            end
        end

        // R8: disable at position 20, magnitudes zero, polarity still tracks, position held
        for (int p = 1; p <= 20; p++) apply(1'b1, 1'b1, 1'b0);
        apply(1'b0, 1'b0, 1'b0);
        check_all("R8 disabled", 20, 1'b0);
        apply(1'b0, 1'b1, 1'b1);
        check_all("R4 disabled strobe ignored", 20, 1'b0);
        apply(1'b1, 1'b0, 1'b0);
        check_all("R8 re-enable", 20, 1'b1);

        // R1: reset mid-run
        do_reset();
        check_all("R1 mid-run reset", 0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule